// File: doc/BRIEF.md
# Multi-Event Round-Trip Latency Histogram

This block measures round-trip latency from one local start moment to several remote acknowledgements. A single-cycle strobe marks the cycle in which the first pixel of a frame begins to leave the device. The strobe arms three timers, which then run together. The remote side reports its progress by writing into the block's register space: one address says the first data word has landed, one says the last data word has landed, and one says its processing has finished. Each of these writes stops its own timer and latches that timer's latency.

Software chooses one of the three events as the histogram source. Every latency that event completes is shifted right by a programmable amount and used as a bin index. Any index past the top goes into the last bin. The chosen bin in a 256-entry memory is then incremented. Each bin update is a read followed by a write, so it takes two cycles. A sample that arrives while an update is in progress waits in a one-entry holding slot. Software reads the bins by address and can zero them all with a sweep. A sweep also runs by itself after reset.

Two sticky flags record protocol misuse. One is set by a stop that arrives for a timer that is not running. The other is set by a start that arrives while any timer is still waiting for its stop.

Top module: `latency_histogram`

## Requirements
- R1: After reset the control word (word 0x000) and status word (word 0x001) read 0 once the automatic clear has finished, and all three latency words read 0. During that clear, bit 16 of the control word reads 1. Afterwards every bin reads 0.
- R2: A start strobe arms all three timers. A write to word 0x010 (first word), 0x011 (last word) or 0x012 (processing done) stops that event's timer. The latency word 0x020, 0x021 or 0x022 then holds the number of cycles from the start strobe to that write. This works for any order of the stops.
- R3: A stop write for an event whose timer is not armed leaves its latency word unchanged and sets status bit 0. The flag stays set until it is cleared.
- R4: A start strobe while any timer is still armed (and is not stopped in the same cycle) sets status bit 1. All timers restart from the new strobe.
- R5: Status bits 4:2 show which timers are armed, with event 0 in bit 2.
- R6: Only the event selected by control bits 1:0 adds samples. Each completed latency L of that event increments the bin at index L >> shift, and the other events leave every bin untouched.
- R7: Control bits 12:8 hold the shift that sets the bin width.
- R8: A shifted latency above 255 is counted in bin 255.
- R9: Samples that arrive in consecutive cycles are all counted, because one sample waits in the holding slot while an update is in progress.
- R10: Writing control bit 16 = 1 zeroes all bins over 256 cycles. Bit 16 of the control word reads 1 until the sweep ends, and samples that arrive during the sweep are not counted.
- R11: Writing control bit 17 = 1 clears both sticky flags.
- R12: A read strobe to word 0x100 + b returns bin b on rd_data_o in the cycle after the strobe. Register words use the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Strobe: first pixel begins transmission |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 10 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 10 | Register read word address |
| rd_data_o | output | 32 | Read data, valid the cycle after the strobe |

## Verification
The hardest situation to reach is a sample that arrives while the single read-modify-write is still busy. Only one event feeds the histogram, and each stop needs its own arming start. So the bench issues a start together with the selected event's stop in three consecutive cycles. Each stop closes the previous arming and each start re-arms the timer, which produces a latency of 1 three times, back to back. The bench then checks that the bin holds exactly 3. Samples that arrive during a clear sweep are produced the same way, with a start and stop while the sweep is in progress.

// File: rtl/latency_histogram_pkg.sv
package latency_histogram_pkg;
    // word addresses of the register space
    localparam int ADR_CTRL = 0;
    localparam int ADR_STAT = 1;
    localparam int ADR_STOP = 16;
    localparam int ADR_LAT  = 32;
    localparam int ADR_BIN  = 256;
    // control and status field positions
    localparam int CTRL_SHIFT_LSB = 8;
    localparam int CTRL_CLR_BINS  = 16;
    localparam int CTRL_CLR_FLAGS = 17;
    localparam int STAT_STRAY     = 0;
    localparam int STAT_OVR       = 1;
    localparam int STAT_ARMED_LSB = 2;

    typedef enum logic {PH_IDLE, PH_WRITE} upd_phase_e;
endpackage

// File: rtl/lat_event_timer.sv
module lat_event_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    output logic             armed_o,
    output logic             done_o,
    output logic [CNT_W-1:0] lat_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             armed;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lat;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.done = 1'b0;
        if (tmr_q.armed && tmr_q.cnt != CNT_MAX) tmr_d.cnt = tmr_q.cnt + 1'b1;
        // latency counts the edges from the start strobe to the stop strobe
        if (stop_i && tmr_q.armed) begin
            tmr_d.armed = 1'b0;
            tmr_d.done  = 1'b1;
            tmr_d.lat   = (tmr_q.cnt == CNT_MAX) ? CNT_MAX : tmr_q.cnt + 1'b1;
        end
        if (start_i) begin
            tmr_d.armed = 1'b1;
            tmr_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign armed_o = tmr_q.armed;
    assign done_o  = tmr_q.done;
    assign lat_o   = tmr_q.lat;
endmodule

// File: rtl/lat_hist_ram.sv
module lat_hist_ram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic          re_b,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata_a <= mem[raddr_a];
        if (re_b) rdata_b <= mem[raddr_b];
    end
endmodule

// File: rtl/lat_hist_engine.sv
module lat_hist_engine
    import latency_histogram_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BIN_W   = 8,
    parameter int SHIFT_W = 5,
    parameter int BCNT_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_v_i,
    input  logic [CNT_W-1:0]   smp_lat_i,
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic               clr_req_i,
    input  logic [BCNT_W-1:0]  ram_rdata_i,
    output logic [BIN_W-1:0]   ram_raddr_o,
    output logic               ram_we_o,
    output logic [BIN_W-1:0]   ram_waddr_o,
    output logic [BCNT_W-1:0]  ram_wdata_o,
    output logic               clr_busy_o,
    output logic               wr_phase_o,
    output logic               hold_o
);
    localparam logic [BIN_W-1:0]  BIN_LAST   = '1;
    localparam logic [CNT_W-1:0]  BIN_LAST_W = CNT_W'(BIN_LAST);
    localparam logic [BCNT_W-1:0] BCNT_MAX   = '1;

    typedef struct packed {
        upd_phase_e       phase;
        logic [BIN_W-1:0] wbin;
        logic             hold_v;
        logic [BIN_W-1:0] hold_bin;
        logic             clr_busy;
        logic [BIN_W-1:0] clr_idx;
    } eng_t;

    localparam eng_t ENG_RST = '{phase: PH_IDLE, wbin: '0, hold_v: 1'b0,
                                 hold_bin: '0, clr_busy: 1'b1, clr_idx: '0};

    eng_t eng_d, eng_q;
    logic [CNT_W-1:0] shifted;
    logic [BIN_W-1:0] in_bin;

    always_comb begin
        shifted = smp_lat_i >> shift_i;
        in_bin  = (shifted > BIN_LAST_W) ? BIN_LAST : shifted[BIN_W-1:0];
    end

    always_comb begin
        eng_d       = eng_q;
        ram_raddr_o = '0;
        ram_we_o    = 1'b0;
        ram_waddr_o = eng_q.wbin;
        ram_wdata_o = (ram_rdata_i == BCNT_MAX) ? BCNT_MAX : ram_rdata_i + 1'b1;
        if (eng_q.clr_busy) begin
            // sweep owns the memory; samples are dropped
            ram_we_o      = 1'b1;
            ram_waddr_o   = eng_q.clr_idx;
            ram_wdata_o   = '0;
            eng_d.clr_idx = eng_q.clr_idx + 1'b1;
            eng_d.phase   = PH_IDLE;
            eng_d.hold_v  = 1'b0;
            if (eng_q.clr_idx == BIN_LAST) eng_d.clr_busy = 1'b0;
        end else begin
            if (eng_q.phase == PH_WRITE) begin
                ram_we_o    = 1'b1;
                eng_d.phase = PH_IDLE;
                if (smp_v_i && !eng_q.hold_v) begin
                    eng_d.hold_v   = 1'b1;
                    eng_d.hold_bin = in_bin;
                end
            end else if (eng_q.hold_v) begin
                ram_raddr_o    = eng_q.hold_bin;
                eng_d.wbin     = eng_q.hold_bin;
                eng_d.phase    = PH_WRITE;
                eng_d.hold_v   = smp_v_i;
                eng_d.hold_bin = in_bin;
            end else if (smp_v_i) begin
                ram_raddr_o = in_bin;
                eng_d.wbin  = in_bin;
                eng_d.phase = PH_WRITE;
            end
            if (clr_req_i) begin
                eng_d.clr_busy = 1'b1;
                eng_d.clr_idx  = '0;
                eng_d.phase    = PH_IDLE;
                eng_d.hold_v   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= ENG_RST;
        else        eng_q <= eng_d;
    end

    assign clr_busy_o = eng_q.clr_busy;
    assign wr_phase_o = (eng_q.phase == PH_WRITE);
    assign hold_o     = eng_q.hold_v;
endmodule

// File: rtl/latency_histogram.sv
module latency_histogram
    import latency_histogram_pkg::*;
#(
    parameter int N_EV    = 3,
    parameter int CNT_W   = 32,
    parameter int BIN_W   = 8,
    parameter int SHIFT_W = 5,
    parameter int BCNT_W  = 32,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int SEL_W = (N_EV > 1) ? $clog2(N_EV) : 1;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
    localparam logic [ADDR_W-1:0] A_STOP = ADDR_W'(ADR_STOP);
    localparam logic [ADDR_W-1:0] A_LAT  = ADDR_W'(ADR_LAT);
    localparam logic [ADDR_W-1:0] A_BIN  = ADDR_W'(ADR_BIN);

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [SHIFT_W-1:0] shift;
        logic               stray;
        logic               ovr;
        logic               rd_bin;
        logic [DATA_W-1:0]  rdata;
    } reg_t;

    reg_t reg_d, reg_q;

    logic [N_EV-1:0]  stop_vec, armed, done;
    logic [CNT_W-1:0] lat [N_EV];
    logic             ctrl_wr, clr_bins_wr, clr_flag_wr;
    logic             smp_v;
    logic [CNT_W-1:0] smp_lat;
    logic             clr_busy, wr_phase, hold_v, rd_in_bins;
    logic             flag_stray, flag_ovr;
    logic [BIN_W-1:0]  ram_raddr, ram_waddr;
    logic              ram_we;
    logic [BCNT_W-1:0] ram_wdata, ram_rdata_a, ram_rdata_b;
    logic [DATA_W-1:0] rmux;
    logic              unused_wr_bits;

    assign ctrl_wr        = wr_en_i && (wr_addr_i == A_CTRL);
    assign clr_bins_wr    = ctrl_wr && wr_data_i[CTRL_CLR_BINS];
    assign clr_flag_wr    = ctrl_wr && wr_data_i[CTRL_CLR_FLAGS];
    assign rd_in_bins     = (rd_addr_i[ADDR_W-1:BIN_W] == A_BIN[ADDR_W-1:BIN_W]);
    assign unused_wr_bits = ^wr_data_i;

    for (genvar e = 0; e < N_EV; e++) begin : g_ev
        assign stop_vec[e] = wr_en_i && (wr_addr_i == A_STOP + ADDR_W'(e));
        lat_event_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .start_i(frame_start_i), .stop_i(stop_vec[e]),
            .armed_o(armed[e]), .done_o(done[e]), .lat_o(lat[e])
        );
    end

    always_comb begin
        smp_v   = 1'b0;
        smp_lat = '0;
        for (int e = 0; e < N_EV; e++) begin
            if (reg_q.sel == SEL_W'(e)) begin
                smp_v   = done[e];
                smp_lat = lat[e];
            end
        end
    end

    lat_hist_engine #(.CNT_W(CNT_W), .BIN_W(BIN_W), .SHIFT_W(SHIFT_W), .BCNT_W(BCNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .smp_v_i(smp_v), .smp_lat_i(smp_lat), .shift_i(reg_q.shift),
        .clr_req_i(clr_bins_wr), .ram_rdata_i(ram_rdata_a), .ram_raddr_o(ram_raddr),
        .ram_we_o(ram_we), .ram_waddr_o(ram_waddr), .ram_wdata_o(ram_wdata),
        .clr_busy_o(clr_busy), .wr_phase_o(wr_phase), .hold_o(hold_v)
    );

    lat_hist_ram #(.AW(BIN_W), .DW(BCNT_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr_a(ram_raddr), .rdata_a(ram_rdata_a),
        .re_b(rd_en_i && rd_in_bins), .raddr_b(rd_addr_i[BIN_W-1:0]), .rdata_b(ram_rdata_b)
    );

    always_comb begin
        rmux = '0;
        if (rd_addr_i == A_CTRL) begin
            rmux[SEL_W-1:0]                  = reg_q.sel;
            rmux[CTRL_SHIFT_LSB +: SHIFT_W]  = reg_q.shift;
            rmux[CTRL_CLR_BINS]              = clr_busy;
        end else if (rd_addr_i == A_STAT) begin
            rmux[STAT_STRAY]                 = reg_q.stray;
            rmux[STAT_OVR]                   = reg_q.ovr;
            rmux[STAT_ARMED_LSB +: N_EV]     = armed;
        end
        for (int e = 0; e < N_EV; e++) begin
            if (rd_addr_i == A_LAT + ADDR_W'(e)) rmux = DATA_W'(lat[e]);
        end
    end

    always_comb begin
        reg_d = reg_q;
        if (ctrl_wr) begin
            reg_d.sel   = wr_data_i[SEL_W-1:0];
            reg_d.shift = wr_data_i[CTRL_SHIFT_LSB +: SHIFT_W];
        end
        reg_d.stray = reg_q.stray | (|(stop_vec & ~armed));
        reg_d.ovr   = reg_q.ovr | (frame_start_i & (|(armed & ~stop_vec)));
        if (clr_flag_wr) begin
            reg_d.stray = 1'b0;
            reg_d.ovr   = 1'b0;
        end
        if (rd_en_i) begin
            reg_d.rd_bin = rd_in_bins;
            if (!rd_in_bins) reg_d.rdata = rmux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign flag_stray = reg_q.stray;
    assign flag_ovr   = reg_q.ovr;
    assign rd_data_o  = reg_q.rd_bin ? DATA_W'(ram_rdata_b) : reg_q.rdata;
endmodule

// File: rtl/latency_histogram_chk.sv
module latency_histogram_chk #(
    parameter int N_EV = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_start,
    input logic [N_EV-1:0] stop_vec,
    input logic [N_EV-1:0] armed,
    input logic            clr_flag_wr,
    input logic            clr_bins_wr,
    input logic            flag_stray,
    input logic            flag_ovr,
    input logic            clr_busy,
    input logic            wr_phase,
    input logic            hold_v
);
    // R2
    all_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> &armed);

    // R3
    stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(stop_vec & ~armed)) && !clr_flag_wr) |=> flag_stray);

    // R3
    stray_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_stray && !clr_flag_wr) |=> flag_stray);

    // R4
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && (|(armed & ~stop_vec)) && !clr_flag_wr) |=> flag_ovr);

    // R9
    write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |=> !wr_phase);

    // R9
    hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v && !wr_phase && !clr_busy && !clr_bins_wr) |=> wr_phase);
endmodule

bind latency_histogram latency_histogram_chk #(.N_EV(N_EV)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start_i), .stop_vec(stop_vec),
    .armed(armed), .clr_flag_wr(clr_flag_wr), .clr_bins_wr(clr_bins_wr),
    .flag_stray(flag_stray), .flag_ovr(flag_ovr), .clr_busy(clr_busy),
    .wr_phase(wr_phase), .hold_v(hold_v)
);

// File: tb/latency_histogram_bench.sv
module latency_histogram_bench;
    import latency_histogram_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  sel;
        logic [4:0]  shift;
        logic [15:0] d0;
        logic [15:0] d1;
        logic [15:0] d2;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 5'd0, 16'd3,   16'd7,   16'd12},
        '{2'd1, 5'd0, 16'd9,   16'd4,   16'd20},
        '{2'd2, 5'd2, 16'd5,   16'd6,   16'd40},
        '{2'd0, 5'd3, 16'd17,  16'd2,   16'd30},
        '{2'd2, 5'd0, 16'd1,   16'd2,   16'd300},
        '{2'd1, 5'd1, 16'd30,  16'd255, 16'd2},
        '{2'd0, 5'd0, 16'd255, 16'd1,   16'd2},
        '{2'd2, 5'd4, 16'd3,   16'd4,   16'd100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [9:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    int exp_bin [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    latency_histogram u_latency_histogram (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic st, input int ev);
        frame_start = st;
        wr_en       = (ev >= 0);
        wr_addr     = (ev >= 0) ? 10'(ADR_STOP + ev) : '0;
        wr_data     = '0;
        @(negedge clk);
        frame_start = 1'b0;
        wr_en       = 1'b0;
    endtask

    task automatic wr_reg(input int a, input logic [31:0] v);
        wr_en   = 1'b1;
        wr_addr = 10'(a);
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] v);
        rd_en   = 1'b1;
        rd_addr = 10'(a);
        @(negedge clk);
        rd_en   = 1'b0;
        v       = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input int d0, input int d1, input int d2);
        int mx;
        mx = (d0 > d1) ? d0 : d1;
        mx = (mx > d2) ? mx : d2;
        tick(1'b1, -1);
        for (int k = 1; k <= mx; k++) begin
            int ev;
            ev = -1;
            if (k == d0) ev = 0;
            else if (k == d1) ev = 1;
            else if (k == d2) ev = 2;
            tick(1'b0, ev);
        end
        idle(4);
    endtask

    function automatic int bin_of(input int lat, input int sh);
        int b;
        b = lat >> sh;
        return (b > 255) ? 255 : b;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] lat_keep;
        for (int b = 0; b < 256; b++) exp_bin[b] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and automatic sweep
        rd_reg(ADR_CTRL, v);     check("R1 clear busy right after reset", v, 32'h0001_0000);
        idle(260);
        rd_reg(ADR_CTRL, v);     check("R1 control after sweep", v, 32'h0);
        rd_reg(ADR_STAT, v);     check("R1 status after reset", v, 32'h0);
        for (int e = 0; e < 3; e++) begin
            rd_reg(ADR_LAT + e, v); check("R1 latency word after reset", v, 32'h0);
        end
        rd_reg(ADR_BIN + 0, v);   check("R1 R12 bin 0 after reset", v, 32'h0);
        rd_reg(ADR_BIN + 255, v); check("R1 R12 bin 255 after reset", v, 32'h0);

        // R2 R6 R7 R8: vector table
        for (int i = 0; i < 8; i++) begin
            int dsel;
            wr_reg(ADR_CTRL, 32'(VECS[i].sel) | (32'(VECS[i].shift) << CTRL_SHIFT_LSB));
            run_frame(int'(VECS[i].d0), int'(VECS[i].d1), int'(VECS[i].d2));
            rd_reg(ADR_LAT + 0, v); check("R2 first-word latency", v, 32'(VECS[i].d0));
            rd_reg(ADR_LAT + 1, v); check("R2 last-word latency", v, 32'(VECS[i].d1));
            rd_reg(ADR_LAT + 2, v); check("R2 done latency", v, 32'(VECS[i].d2));
            dsel = (VECS[i].sel == 2'd0) ? int'(VECS[i].d0) :
                   (VECS[i].sel == 2'd1) ? int'(VECS[i].d1) : int'(VECS[i].d2);
            exp_bin[bin_of(dsel, int'(VECS[i].shift))]++;
        end
        rd_reg(ADR_STAT, v); check("R4 no overrun when every stop arrives", v, 32'h0);
        for (int b = 0; b < 256; b++) begin
            rd_reg(ADR_BIN + b, v);
            check("R6 R7 R8 R12 bin contents", v, 32'(exp_bin[b]));
        end

        // R5: armed bits
        wr_reg(ADR_CTRL, 32'h0);
        tick(1'b1, -1);
        rd_reg(ADR_STAT, v); check("R5 all armed", v, 32'h1C);
        tick(1'b0, 1);
        rd_reg(ADR_STAT, v); check("R5 event 1 disarmed", v, 32'h14);
        tick(1'b0, 0);
        tick(1'b0, 2);
        rd_reg(ADR_STAT, v); check("R5 none armed", v, 32'h0);
        rd_reg(ADR_LAT + 0, v); check("R2 first-word after out-of-order stops", v, 32'd4);
        rd_reg(ADR_LAT + 2, v); check("R2 done after out-of-order stops", v, 32'd5);

        // R3: stray stop
        rd_reg(ADR_LAT + 1, lat_keep); check("R2 last-word before stray", lat_keep, 32'd2);
        tick(1'b0, 1);
        idle(2);
        rd_reg(ADR_STAT, v);    check("R3 stray flag set", v, 32'h1);
        rd_reg(ADR_LAT + 1, v); check("R3 latency unchanged by stray stop", v, lat_keep);
        idle(3);
        rd_reg(ADR_STAT, v);    check("R3 stray flag sticky", v, 32'h1);

        // R11: clear flags
        wr_reg(ADR_CTRL, 32'h1 << CTRL_CLR_FLAGS);
        rd_reg(ADR_STAT, v); check("R11 flags cleared", v, 32'h0);

        // R4: overrun and restart
        tick(1'b1, -1);
        idle(4);
        tick(1'b1, -1);
        idle(2);
        tick(1'b0, 0);
        tick(1'b0, 1);
        idle(1);
        tick(1'b0, 2);
        idle(3);
        rd_reg(ADR_STAT, v);    check("R4 overrun flag", v, 32'h2);
        rd_reg(ADR_LAT + 0, v); check("R4 restart first-word", v, 32'd3);
        rd_reg(ADR_LAT + 1, v); check("R4 restart last-word", v, 32'd4);
        rd_reg(ADR_LAT + 2, v); check("R4 restart done", v, 32'd6);
        wr_reg(ADR_CTRL, 32'h1 << CTRL_CLR_FLAGS);

        // R10: clear sweep, samples during sweep ignored
        wr_reg(ADR_CTRL, 32'h1 << CTRL_CLR_BINS);
        rd_reg(ADR_CTRL, v); check("R10 busy during sweep", v, 32'h0001_0000);
        tick(1'b1, -1);
        idle(1);
        tick(1'b0, 0);
        tick(1'b0, 1);
        tick(1'b0, 2);
        idle(300);
        rd_reg(ADR_CTRL, v); check("R10 busy cleared", v, 32'h0);
        for (int b = 0; b < 256; b++) begin
            rd_reg(ADR_BIN + b, v);
            check("R10 bin zero after sweep", v, 32'h0);
        end

        // R9: back-to-back samples through the holding slot
        wr_reg(ADR_CTRL, 32'h1 << CTRL_CLR_FLAGS);
        tick(1'b1, -1);
        tick(1'b1, 0);
        tick(1'b1, 0);
        tick(1'b0, 0);
        tick(1'b0, 1);
        tick(1'b0, 2);
        idle(8);
        rd_reg(ADR_BIN + 1, v); check("R9 three back-to-back samples", v, 32'd3);
        rd_reg(ADR_BIN + 0, v); check("R9 neighbour bin 0 untouched", v, 32'd0);
        rd_reg(ADR_BIN + 2, v); check("R6 unselected events add nothing", v, 32'd0);
        rd_reg(ADR_STAT, v);    check("R4 overrun from re-arming starts", v, 32'h2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule